// File: doc/BRIEF.md
# Table-Driven Six-Digit BCD Counter

This block is a free-running decimal counter that holds six BCD digits. The digits are split into a lower half and an upper half of three digits each. Neither half has an adder of its own. Both halves share one next-count lookup table that has two read ports.

Each half presents its current three-digit value to its own port. The port returns the value plus one, together with a carry flag that is set only when the half reads all nines. A small link stage decides when each half may load its table result. The lower half advances on every enabled clock. The upper half advances only when the lower half wraps.

The number of digits per half is a parameter, three by default. A terminal flag reports the moment the whole count stands at its largest value. The next enabled clock takes the counter back to zero.

Top module: `bcd_table_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every digit, so `count` reads zero after that edge whatever `en` is.
- R2: With `en` low and `rst` low, a rising edge leaves `count` unchanged.
- R3: With `en` high, each rising edge adds one in decimal to the lower half: a digit at 9 becomes 0 and carries into the next digit of the same half.
- R4: The upper half advances by exactly one only on an enabled edge where the lower half reads all nines. On that same edge the lower half returns to zero. On every other edge the upper half holds.
- R5: `at_max` is high exactly while `count` reads all nines in every digit (999999 by default). It follows the stored count, with no extra cycle of delay.
- R6: From the all-nines count, an enabled edge gives `count` equal to zero. The table entry that carries always returns a zero value.
- R7: `count` is always valid BCD: digit k sits at bits 4k+3 down to 4k and is never above 9. The lower half occupies the low 4*HALF_DIGITS bits.
- R8: The `count` width is 8*HALF_DIGITS bits, which is 24 bits with the default HALF_DIGITS of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| en | input | 1 | Count enable |
| count | output | 8*HALF_DIGITS | Packed BCD count, least significant digit in bits 3:0 |
| at_max | output | 1 | High while every digit is 9 |

## Verification
The bench builds two copies of the counter. The first uses the default of three digits per half, and its low-to-high carry (000999 to 001000) is reached within a thousand enabled cycles. The second uses two digits per half, which gives a four-digit counter with 10,000 states. With that copy the run can reach the all-nines count, watch `at_max`, and see the wrap to zero; a six-digit counter would need a million enabled cycles for the same walk. Both copies get the same random enable and reset pattern and are compared against integer reference counts, the first modulo 1,000,000 and the second modulo 10,000.

// File: rtl/bcd_table_pkg.sv
package bcd_table_pkg;

    // Widest half the shared table function supports.
    localparam int unsigned MAX_HALF_DIGITS = 4;
    localparam int unsigned MAX_HALF_W      = 4 * MAX_HALF_DIGITS;

    typedef logic [MAX_HALF_W-1:0] half_word_t;

    // One table entry: incremented value plus rollover flag.
    typedef struct packed {
        logic       carry;
        half_word_t value;
    } inc_entry_t;

    function automatic logic digit_ok(input logic [3:0] d);
        return d <= 4'd9;
    endfunction

    function automatic logic word_is_bcd(input half_word_t w, input int unsigned nd);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < MAX_HALF_DIGITS; i++) begin
            if (i < nd && !digit_ok(w[4*i +: 4])) ok = 1'b0;
        end
        return ok;
    endfunction

    // Contents of the increment table at one address. Non-BCD
    // addresses yield zero with no carry.
    function automatic inc_entry_t inc_lookup(input half_word_t addr, input int unsigned nd);
        inc_entry_t r;
        logic       ripple;
        logic       bad;
        logic [3:0] d;
        r      = '0;
        ripple = 1'b1;
        bad    = 1'b0;
        for (int i = 0; i < MAX_HALF_DIGITS; i++) begin
            if (i < nd) begin
                d = addr[4*i +: 4];
                if (!digit_ok(d)) bad = 1'b1;
                if (ripple) begin
                    if (d == 4'd9) begin
                        r.value[4*i +: 4] = 4'd0;
                    end else begin
                        r.value[4*i +: 4] = d + 4'd1;
                        ripple = 1'b0;
                    end
                end else begin
                    r.value[4*i +: 4] = d;
                end
            end
        end
        if (bad) begin
            r = '0;
        end else begin
            r.carry = ripple;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_inc_table.sv
module bcd_inc_table
    import bcd_table_pkg::*;
#(
    parameter int unsigned DIGITS = 3,
    parameter int unsigned PORTS  = 2
) (
    input  logic [PORTS-1:0][4*DIGITS-1:0] rd_addr,
    output logic [PORTS-1:0][4*DIGITS-1:0] rd_value,
    output logic [PORTS-1:0]               rd_carry
);
    localparam int unsigned W = 4 * DIGITS;

    // Every port reads the same table contents.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        inc_entry_t entry;
        always_comb begin
            entry = inc_lookup(half_word_t'(rd_addr[p]), DIGITS);
        end
        assign rd_value[p] = entry.value[W-1:0];
        assign rd_carry[p] = entry.carry;
    end

endmodule

// File: rtl/bcd_half_reg.sv
module bcd_half_reg
    import bcd_table_pkg::*;
#(
    parameter int unsigned DIGITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic [4*DIGITS-1:0] next_value,
    output logic [4*DIGITS-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (adv) begin
            value <= next_value;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> value == '0);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(value));

    assert_digits_valid_R7: assert property (@(posedge clk) disable iff (rst)
        adv |=> word_is_bcd(half_word_t'(value), DIGITS));

endmodule

// File: rtl/bcd_carry_link.sv
module bcd_carry_link (
    input  logic en,
    input  logic lo_carry,
    input  logic hi_carry,
    output logic lo_adv,
    output logic hi_adv,
    output logic all_max
);
    // Table carries are set only for an all-nines half.
    always_comb begin
        lo_adv  = en;
        hi_adv  = en & lo_carry;
        all_max = lo_carry & hi_carry;
    end
endmodule

// File: rtl/bcd_table_counter.sv
module bcd_table_counter
    import bcd_table_pkg::*;
#(
    parameter int unsigned HALF_DIGITS = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    output logic [8*HALF_DIGITS-1:0] count,
    output logic                     at_max
);
    localparam int unsigned HW = 4 * HALF_DIGITS;
    localparam int unsigned LO = 0;
    localparam int unsigned HI = 1;

    logic [1:0][HW-1:0] cur;
    logic [1:0][HW-1:0] nxt;
    logic [1:0]         cy;
    logic [1:0]         adv;

    bcd_inc_table #(.DIGITS(HALF_DIGITS), .PORTS(2)) u_table (
        .rd_addr  (cur),
        .rd_value (nxt),
        .rd_carry (cy)
    );

    bcd_carry_link u_link (
        .en       (en),
        .lo_carry (cy[LO]),
        .hi_carry (cy[HI]),
        .lo_adv   (adv[LO]),
        .hi_adv   (adv[HI]),
        .all_max  (at_max)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        bcd_half_reg #(.DIGITS(HALF_DIGITS)) u_half (
            .clk        (clk),
            .rst        (rst),
            .adv        (adv[h]),
            .next_value (nxt[h]),
            .value      (cur[h])
        );
    end

    assign count = {cur[HI], cur[LO]};

    assert_upper_waits_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !cy[LO]) |=> $stable(cur[HI]));

    assert_lower_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (en && cy[LO]) |=> cur[LO] == '0);

    assert_full_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (en && at_max) |=> count == '0);

    assert_carry_value_zero_R6: assert property (@(posedge clk) disable iff (rst)
        cy[LO] |-> nxt[LO] == '0);

endmodule

// File: tb/test_bcd_table_counter.sv
module test_bcd_table_counter;
    localparam time CLK_P = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [23:0] count6;
    logic        max6;
    logic [15:0] count4;
    logic        max4;

    int checks   = 0;
    int failures = 0;
    int ref6     = 0;
    int ref4     = 0;

    always #(CLK_P/2) clk = ~clk;

    bcd_table_counter i_bcd_table_counter (
        .clk(clk), .rst(rst), .en(en), .count(count6), .at_max(max6)
    );

    bcd_table_counter #(.HALF_DIGITS(2)) i_bcd_table_counter_small (
        .clk(clk), .rst(rst), .en(en), .count(count4), .at_max(max4)
    );

    function automatic logic [31:0] to_bcd(input int v);
        logic [31:0] r;
        int x;
        r = '0;
        x = v;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic bit bcd_ok(input logic [31:0] w, input int nd);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < nd; i++) if (w[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    task automatic check(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic e, input string tag);
        logic [31:0] e6, e4;
        bit wrap4;
        rst = r;
        en  = e;
        wrap4 = !r && e && (ref4 == 9999);
        @(posedge clk);
        if (r) begin
            ref6 = 0;
            ref4 = 0;
        end else if (e) begin
            ref6 = (ref6 + 1) % 1000000;
            ref4 = (ref4 + 1) % 10000;
        end
        @(negedge clk);
        e6 = to_bcd(ref6);
        e4 = to_bcd(ref4);
        check(tag, count6 == e6[23:0], longint'(count6), longint'(e6[23:0]));
        check(tag, count4 == e4[15:0], longint'(count4), longint'(e4[15:0]));
        check("R5", max6 == (ref6 == 999999), longint'(max6), longint'(ref6 == 999999));
        check("R5", max4 == (ref4 == 9999), longint'(max4), longint'(ref4 == 9999));
        check("R7", bcd_ok({8'h0, count6}, 6), longint'(count6), longint'(e6[23:0]));
        check("R7", bcd_ok({16'h0, count4}, 4), longint'(count4), longint'(e4[15:0]));
        if (wrap4) check("R6", count4 == 16'h0, longint'(count4), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic e;
        void'($urandom(32'h5eed_0c7e));
        @(negedge clk);
        cyc(1'b1, 1'b0, "R1");
        cyc(1'b1, 1'b1, "R1");
        check("R8", $bits(count6) == 24, $bits(count6), 24);
        check("R8", $bits(count4) == 16, $bits(count4), 16);

        // Random enable with occasional reset.
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 97) == 0) begin
                cyc(1'b1, 1'b0, "R1");
            end else begin
                e = 1'($urandom % 2);
                cyc(1'b0, e, e ? "R3" : "R2");
            end
        end

        // Directed: lower half rollover into upper half.
        cyc(1'b1, 1'b0, "R1");
        while (ref6 != 999) cyc(1'b0, 1'b1, "R3");
        cyc(1'b0, 1'b0, "R2");
        check("R5", max6 == 1'b0, longint'(max6), 0);
        cyc(1'b0, 1'b1, "R4");
        check("R4", count6 == 24'h001000, longint'(count6), 24'h001000);
        cyc(1'b0, 1'b1, "R3");

        // Directed: walk the small counter to all nines and wrap.
        while (ref4 != 9999) begin
            e = (($urandom % 8) != 0);
            cyc(1'b0, e, e ? "R3" : "R2");
        end
        check("R5", max4 == 1'b1, longint'(max4), 1);
        cyc(1'b0, 1'b0, "R2");
        check("R5", max4 == 1'b1, longint'(max4), 1);
        cyc(1'b0, 1'b1, "R6");
        check("R6", count4 == 16'h0000, longint'(count4), 0);
        check("R6", max4 == 1'b0, longint'(max4), 0);
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, "R3");
        cyc(1'b1, 1'b1, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule